// File: doc/BRIEF.md
# LUT-Based Silicon Strip Cluster Finder

This block scans one silicon strip sensor for clusters. Each clock cycle it takes the whole hit frame, 128 bits with one bit per strip, and returns the list of clusters it found one cycle later. A cluster is a run of neighbouring strips that all carry a hit. For each cluster the block reports where its centre lies and how wide it is. The target clock is 40 MHz, and the full frame is handled in that single cycle.

The frame is cut into 32 slices of four strips. A small table decodes each slice into three things: the places inside it where a run opens, the places where a run closes, and whether its lowest or highest strip is lit. Seam logic looks at neighbouring slices. It removes any open or close marker that sits on a slice boundary where the run in fact carries on into the next slice, so a run that crosses several slices counts as one cluster.

A list builder then walks the markers. It drops clusters that are wider than a programmable limit, keeps up to eight of the rest in ascending order, and records whether more qualifying clusters existed than the list can hold. The block has no sequencing state beyond its output registers and the sticky overflow bit.

Top module: `strip_cluster_finder`

## Requirements
- R1: Outputs are registered. A frame presented before a rising clock edge appears on the outputs just after that edge, and the outputs keep their value until the next edge. A synchronous active-high `rst` clears every valid bit, position, width and the overflow flag.
- R2: A cluster is a maximal run of adjacent hit strips. Its position is the sum of its first and last strip index (half-strip units, 8 bits), and its width is the number of strips in the run.
- R3: A run that crosses one or more 4-strip slice boundaries is reported as a single cluster. A run that exactly fills one slice, with both neighbours empty, is also a single cluster.
- R4: A cluster whose width is greater than `max_width_i` is discarded. A width equal to the limit is kept. A limit of 0 discards every cluster.
- R5: Entry k of the list occupies bits [8k+7:8k] of `clu_pos_o` and `clu_width_o`, with valid bit k of `clu_valid_o`. Kept clusters fill entries from 0 upward in ascending position, and entries without a cluster read as zero.
- R6: When more than 8 clusters pass the width limit in one frame, the first 8 are listed and `overflow_o` is set. The flag stays set until reset. Clusters discarded by the width limit do not count toward overflow.
- R7: Clusters touching strip 0 or strip 127 are reported normally. No run wraps from one end of the sensor to the other.
- R8: A frame with all 128 strips hit gives one cluster of position 127 and width 128.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hits_i | input | 128 | Strip hit frame, bit i is strip i |
| max_width_i | input | 8 | Largest cluster width that is kept |
| clu_valid_o | output | 8 | Valid bit per list entry |
| clu_pos_o | output | 64 | Entry positions, 8 bits per entry |
| clu_width_o | output | 64 | Entry widths, 8 bits per entry |
| overflow_o | output | 1 | Sticky: some frame had more than 8 kept clusters |

## Verification
The hardest case to reach from the ports is the interaction between the width filter and the overflow flag. A frame can hold many clusters that must all be filtered out without raising overflow, while a frame with one kept cluster too many must raise it. The bench first sends twelve clusters of width 3 against a limit of 2 and expects an empty list with the flag clear. It then sends exactly eight clusters, then nine, then an empty frame to show the flag stays set. Runs spanning three slices, runs on both sensor ends and a full frame exercise the seam logic at every kind of boundary.

// File: rtl/scf_pkg.sv
package scf_pkg;

    // Strips decoded by one lookup slice
    localparam int SLICE_W = 4;

    typedef struct packed {
        logic [SLICE_W-1:0] first;   // a run opens at this strip (inside the slice)
        logic [SLICE_W-1:0] last;    // a run closes at this strip (inside the slice)
        logic               lo_edge; // lowest strip of the slice is hit
        logic               hi_edge; // highest strip of the slice is hit
    } slice_code_t;

    // Content of one slice table entry, computed from the strip pattern
    function automatic slice_code_t slice_decode(input logic [SLICE_W-1:0] s);
        slice_code_t c;
        logic [SLICE_W-1:0] below;
        logic [SLICE_W-1:0] above;
        below     = {s[SLICE_W-2:0], 1'b0};
        above     = {1'b0, s[SLICE_W-1:1]};
        c.first   = s & ~below;
        c.last    = s & ~above;
        c.lo_edge = s[0];
        c.hi_edge = s[SLICE_W-1];
        return c;
    endfunction

endpackage

// File: rtl/scf_slice_lut.sv
module scf_slice_lut
    import scf_pkg::*;
(
    input  logic [SLICE_W-1:0] strips_i,
    output slice_code_t        code_o
);

    localparam int ENTRIES = 1 << SLICE_W;

    slice_code_t rom [ENTRIES];

    for (genvar k = 0; k < ENTRIES; k++) begin : g_rom
        assign rom[k] = slice_decode(SLICE_W'(k));
    end

    assign code_o = rom[strips_i];

endmodule

// File: rtl/scf_merge.sv
module scf_merge
    import scf_pkg::*;
#(
    parameter int NUM_SLICES = 32,
    localparam int NUM_STRIPS = NUM_SLICES * SLICE_W
) (
    input  slice_code_t            codes_i [NUM_SLICES],
    output logic [NUM_STRIPS-1:0]  start_o,
    output logic [NUM_STRIPS-1:0]  stop_o
);

    localparam logic [SLICE_W-2:0] ZPAD = '0;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_seam
        logic carry_in;   // run continues from the slice below
        logic carry_out;  // run continues into the slice above

        if (s == 0) begin : g_lo
            assign carry_in = 1'b0;
        end else begin : g_lo
            assign carry_in = codes_i[s-1].hi_edge;
        end

        if (s == NUM_SLICES - 1) begin : g_hi
            assign carry_out = 1'b0;
        end else begin : g_hi
            assign carry_out = codes_i[s+1].lo_edge;
        end

        assign start_o[s*SLICE_W +: SLICE_W] = codes_i[s].first & ~{ZPAD, carry_in};
        assign stop_o[s*SLICE_W +: SLICE_W]  = codes_i[s].last  & ~{carry_out, ZPAD};
    end

endmodule

// File: rtl/scf_list_builder.sv
module scf_list_builder #(
    parameter int NUM_STRIPS = 128,
    parameter int MAX_CLUST  = 8,
    localparam int IDX_W = $clog2(NUM_STRIPS),
    localparam int POS_W = IDX_W + 1
) (
    input  logic [NUM_STRIPS-1:0]            start_i,
    input  logic [NUM_STRIPS-1:0]            stop_i,
    input  logic [POS_W-1:0]                 max_width_i,
    output logic [MAX_CLUST-1:0]             valid_o,
    output logic [MAX_CLUST-1:0][POS_W-1:0]  pos_o,
    output logic [MAX_CLUST-1:0][POS_W-1:0]  wid_o,
    output logic                             excess_o
);

    localparam int CNT_W = $clog2(MAX_CLUST + 1);
    localparam int SEL_W = $clog2(MAX_CLUST);

    always_comb begin
        logic [IDX_W-1:0] open_at;
        logic [CNT_W-1:0] fill;
        logic [POS_W-1:0] span;
        open_at  = '0;
        fill     = '0;
        span     = '0;
        excess_o = 1'b0;
        valid_o  = '0;
        pos_o    = '0;
        wid_o    = '0;
        for (int i = 0; i < NUM_STRIPS; i++) begin
            if (start_i[i]) begin
                open_at = IDX_W'(i);
            end
            if (stop_i[i]) begin
                span = POS_W'(i) - POS_W'(open_at) + POS_W'(1);
                if (span <= max_width_i) begin
                    if (fill < CNT_W'(MAX_CLUST)) begin
                        pos_o[fill[SEL_W-1:0]]   = POS_W'(open_at) + POS_W'(i);
                        wid_o[fill[SEL_W-1:0]]   = span;
                        valid_o[fill[SEL_W-1:0]] = 1'b1;
                        fill = fill + CNT_W'(1);
                    end else begin
                        excess_o = 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/strip_cluster_finder.sv
module strip_cluster_finder
    import scf_pkg::*;
#(
    parameter int NUM_STRIPS = 128,
    parameter int MAX_CLUST  = 8
) (
    input  logic                                          clk,
    input  logic                                          rst,
    input  logic [NUM_STRIPS-1:0]                         hits_i,
    input  logic [$clog2(NUM_STRIPS):0]                   max_width_i,
    output logic [MAX_CLUST-1:0]                          clu_valid_o,
    output logic [MAX_CLUST*($clog2(NUM_STRIPS)+1)-1:0]   clu_pos_o,
    output logic [MAX_CLUST*($clog2(NUM_STRIPS)+1)-1:0]   clu_width_o,
    output logic                                          overflow_o
);

    localparam int NUM_SLICES = NUM_STRIPS / SLICE_W;
    localparam int POS_W      = $clog2(NUM_STRIPS) + 1;

    slice_code_t                     codes [NUM_SLICES];
    logic [NUM_STRIPS-1:0]           run_start;
    logic [NUM_STRIPS-1:0]           run_stop;
    logic [MAX_CLUST-1:0]            nxt_valid, valid_q;
    logic [MAX_CLUST-1:0][POS_W-1:0] nxt_pos, pos_q;
    logic [MAX_CLUST-1:0][POS_W-1:0] nxt_wid, wid_q;
    logic                            nxt_excess, ovf_q;

    for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
        scf_slice_lut u_lut (
            .strips_i (hits_i[s*SLICE_W +: SLICE_W]),
            .code_o   (codes[s])
        );
    end

    scf_merge #(.NUM_SLICES(NUM_SLICES)) u_merge (
        .codes_i (codes),
        .start_o (run_start),
        .stop_o  (run_stop)
    );

    scf_list_builder #(.NUM_STRIPS(NUM_STRIPS), .MAX_CLUST(MAX_CLUST)) u_list (
        .start_i     (run_start),
        .stop_i      (run_stop),
        .max_width_i (max_width_i),
        .valid_o     (nxt_valid),
        .pos_o       (nxt_pos),
        .wid_o       (nxt_wid),
        .excess_o    (nxt_excess)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= '0;
            pos_q   <= '0;
            wid_q   <= '0;
            ovf_q   <= 1'b0;
        end else begin
            valid_q <= nxt_valid;
            pos_q   <= nxt_pos;
            wid_q   <= nxt_wid;
            ovf_q   <= ovf_q | nxt_excess;
        end
    end

    assign clu_valid_o = valid_q;
    assign clu_pos_o   = pos_q;
    assign clu_width_o = wid_q;
    assign overflow_o  = ovf_q;

endmodule

// File: rtl/scf_checker.sv
module scf_checker #(
    parameter int NUM_STRIPS = 128,
    parameter int MAX_CLUST  = 8,
    localparam int PW = $clog2(NUM_STRIPS) + 1
) (
    input logic                    clk,
    input logic                    rst,
    input logic [PW-1:0]           max_width_i,
    input logic [MAX_CLUST-1:0]    clu_valid_o,
    input logic [MAX_CLUST*PW-1:0] clu_pos_o,
    input logic [MAX_CLUST*PW-1:0] clu_width_o,
    input logic                    overflow_o
);

    assert_reset_clears_R1: assert property (@(posedge clk)
        rst |=> (clu_valid_o == '0 && !overflow_o));

    assert_sticky_overflow_R6: assert property (@(posedge clk) disable iff (rst)
        overflow_o |=> overflow_o);

    assert_overflow_full_R6: assert property (@(posedge clk) disable iff (rst)
        $rose(overflow_o) |-> (&clu_valid_o));

    for (genvar k = 0; k < MAX_CLUST; k++) begin : g_ent
        logic [PW-1:0] p;
        logic [PW-1:0] w;
        assign p = clu_pos_o[k*PW +: PW];
        assign w = clu_width_o[k*PW +: PW];

        // first+last and last-first+1 always have opposite parity
        assert_pos_parity_R2: assert property (@(posedge clk) disable iff (rst)
            clu_valid_o[k] |-> (p[0] != w[0] && p >= w - PW'(1)));

        assert_width_limit_R4: assert property (@(posedge clk) disable iff (rst)
            clu_valid_o[k] |-> (w != '0 && w <= $past(max_width_i)));

        assert_empty_zero_R5: assert property (@(posedge clk) disable iff (rst)
            !clu_valid_o[k] |-> (p == '0 && w == '0));

        if (k > 0) begin : g_ord
            logic [PW-1:0] q;
            assign q = clu_pos_o[(k-1)*PW +: PW];
            assert_ascending_R5: assert property (@(posedge clk) disable iff (rst)
                clu_valid_o[k] |-> (clu_valid_o[k-1] && p > q));
        end
    end

endmodule

bind strip_cluster_finder scf_checker #(
    .NUM_STRIPS (NUM_STRIPS),
    .MAX_CLUST  (MAX_CLUST)
) u_scf_checker (
    .clk         (clk),
    .rst         (rst),
    .max_width_i (max_width_i),
    .clu_valid_o (clu_valid_o),
    .clu_pos_o   (clu_pos_o),
    .clu_width_o (clu_width_o),
    .overflow_o  (overflow_o)
);

// File: tb/strip_cluster_finder_bench.sv
`timescale 1ns/1ps
module strip_cluster_finder_bench;

    localparam int NS = 128;
    localparam int MC = 8;
    localparam int PW = 8;

    logic              clk  = 1'b0;
    logic              rst  = 1'b1;
    logic [NS-1:0]     hits = '0;
    logic [PW-1:0]     maxw = 8'd128;
    logic [MC-1:0]     vld;
    logic [MC*PW-1:0]  pos;
    logic [MC*PW-1:0]  wid;
    logic              ovf;

    logic [MC-1:0]     e_vld = '0;
    logic [MC*PW-1:0]  e_pos = '0;
    logic [MC*PW-1:0]  e_wid = '0;
    logic              e_ovf = 1'b0;

    int n_checks = 0;
    int n_fail   = 0;

    always #2.5 clk = ~clk;

    strip_cluster_finder u_strip_cluster_finder (
        .clk         (clk),
        .rst         (rst),
        .hits_i      (hits),
        .max_width_i (maxw),
        .clu_valid_o (vld),
        .clu_pos_o   (pos),
        .clu_width_o (wid),
        .overflow_o  (ovf)
    );

    function automatic logic [NS-1:0] runs(int first, int stride, int len, int count);
        logic [NS-1:0] v;
        v = '0;
        for (int c = 0; c < count; c++) begin
            for (int b = 0; b < len; b++) begin
                v[first + c*stride + b] = 1'b1;
            end
        end
        return v;
    endfunction

    task automatic check_field(string tag, string what, logic [MC*PW-1:0] act, logic [MC*PW-1:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic compare_all(string tag);
        check_field(tag, "valid",    {{(MC*PW-MC){1'b0}}, vld}, {{(MC*PW-MC){1'b0}}, e_vld});
        check_field(tag, "position", pos, e_pos);
        check_field(tag, "width",    wid, e_wid);
        check_field(tag, "overflow", {{(MC*PW-1){1'b0}}, ovf}, {{(MC*PW-1){1'b0}}, e_ovf});
    endtask

    // Expected list from the requirements: scan maximal runs low to high
    task automatic predict(logic [NS-1:0] h, logic [PW-1:0] mw);
        int n;
        int i;
        int j;
        n = 0;
        i = 0;
        e_vld = '0;
        e_pos = '0;
        e_wid = '0;
        while (i < NS) begin
            if (h[i]) begin
                j = i;
                while (j + 1 < NS && h[j+1]) j++;
                if (j - i + 1 <= int'(mw)) begin
                    if (n < MC) begin
                        e_vld[n]          = 1'b1;
                        e_pos[n*PW +: PW] = PW'(i + j);
                        e_wid[n*PW +: PW] = PW'(j - i + 1);
                    end
                    n++;
                end
                i = j + 1;
            end else begin
                i++;
            end
        end
        if (n > MC) e_ovf = 1'b1;
    endtask

    // Called at a falling edge; checks at the next falling edge
    task automatic apply(logic [NS-1:0] h, logic [PW-1:0] mw, string tag);
        hits = h;
        maxw = mw;
        predict(h, mw);
        @(negedge clk);
        compare_all(tag);
    endtask

    task automatic t_reset();
        rst  = 1'b1;
        @(negedge clk);
        e_vld = '0; e_pos = '0; e_wid = '0; e_ovf = 1'b0;
        compare_all("R1 reset");
        rst = 1'b0;
    endtask

    task automatic t_single();
        apply(runs(5, 1, 1, 1), 8'd128, "R2 single");        // pos 10 width 1
        apply(runs(60, 1, 3, 1) | runs(100, 1, 2, 1), 8'd128, "R2 pair");
    endtask

    task automatic t_seams();
        apply(runs(3, 1, 3, 1), 8'd128, "R3 two slices");     // 3..5: pos 8 width 3
        apply(runs(2, 1, 8, 1), 8'd128, "R3 three slices");   // 2..9: pos 11 width 8
        apply(runs(4, 1, 4, 1), 8'd128, "R3 full slice");     // 4..7: pos 11 width 4
        apply(runs(0, 4, 4, 2) ^ runs(4, 1, 1, 1), 8'd128, "R3 split at seam");
    endtask

    task automatic t_ends();
        apply(runs(0, 127, 1, 2), 8'd128, "R7 single ends");  // pos 0 and 254
        apply(runs(0, 1, 2, 1) | runs(125, 1, 3, 1), 8'd128, "R7 runs at ends");
    endtask

    task automatic t_full();
        apply({NS{1'b1}}, 8'd128, "R8 all hit");              // pos 127 width 128
    endtask

    task automatic t_width();
        logic [NS-1:0] f;
        f = runs(10, 1, 2, 1) | runs(20, 1, 3, 1) | runs(30, 1, 4, 1);
        apply(f, 8'd3, "R4 limit 3");
        apply(f, 8'd4, "R4 limit 4");
        apply(f, 8'd0, "R4 limit 0");
    endtask

    task automatic t_latency();
        apply(runs(40, 1, 2, 1), 8'd128, "R1 frame A");
        hits = runs(90, 1, 1, 1);
        #1;
        compare_all("R1 hold before edge");
        predict(hits, maxw);
        @(negedge clk);
        compare_all("R1 frame B");
    endtask

    task automatic t_overflow();
        apply(runs(10, 10, 3, 12), 8'd2, "R6 wide ignored");
        apply(runs(5, 10, 2, 8), 8'd128, "R6 exactly eight");
        apply(runs(5, 10, 2, 9), 8'd128, "R5 R6 nine");
        apply('0, 8'd128, "R6 sticky empty");
        apply(runs(0, 2, 1, 64), 8'd128, "R5 alternating");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        t_single();
        t_seams();
        t_ends();
        t_full();
        t_width();
        t_latency();
        t_overflow();
        t_reset();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule